// File: doc/BRIEF.md
# Mode-Selectable Dual-Clock FIFO

A first-in first-out buffer with an independent write clock and read clock. Words enter on the write port when the write enable is high and there is room. They leave on the read port in the order they were written. The storage is a simple dual-port memory with a registered read, so an FPGA can map it onto block RAM. Both sides see the other side's pointer through Gray-coded two-flop synchronizers. The empty-side status is computed in the read clock domain and the full-side status in the write clock domain.

A master reset chooses one of two read disciplines and holds that choice until the next master reset. In the demand-read (standard) discipline, every word reaches the output only through an explicit read, and the two status pins carry an empty flag and a full flag. In the fall-through discipline, the head word is moved to the output without a read. The same two pins then carry "output word valid" and "room to write", so their polarity is reversed. A partial reset clears both pointers but keeps the chosen discipline. A rewind input moves the read pointer back to the first memory location so that data written since the last reset can be replayed.

A half-full flag reports, in the write domain, when more than half of the memory is in use. Depth and word width are parameters. The depth must be a power of two.

Top module: `mode_fifo`

## Requirements
- R1: While `mrst` is high on a clock edge, `fwft_sel` selects the discipline: 1 gives fall-through, 0 gives demand-read. `fwft_sel` has no effect while `mrst` is low.
- R2: In demand-read mode, `dout` changes only on an `rclk` edge that has `rd_en` high while the FIFO is not empty. It then shows the oldest unread word. On every other edge it holds its value.
- R3: In demand-read mode, `st_rd` is an empty flag (1 = nothing to read) and `st_wr` is a full flag (1 = DEPTH words held in memory).
- R4: In fall-through mode, a word written into an empty FIFO at a `wclk` edge is on `dout`, with `st_rd` = 1, after the third `rclk` edge that follows. No `rd_en` is needed for this.
- R5: In fall-through mode, `st_rd` = 1 means `dout` holds a valid word. `rd_en` while valid either advances `dout` to the next word or clears `st_rd`. `st_wr` = 1 means there is room to write. Capacity is DEPTH+1 words: DEPTH in memory plus one on the output.
- R6: A write while full is dropped and its data is never delivered. A read while empty changes neither `dout` nor the read pointer.
- R7: After a write into an empty demand-read FIFO, `st_rd` stays 1 after the write edge and the next `rclk` edge, and falls after the second `rclk` edge that follows.
- R8: `half_full` is 1 when the number of words in memory, as seen by the write side, is greater than DEPTH/2.
- R9: After a master or partial reset edge, both pointers point to the first location and the FIFO is empty. `half_full` is 0, `st_rd` equals the empty indication of the current mode (1 in demand-read, 0 in fall-through), and `st_wr` equals the not-full indication of the current mode (0 in demand-read, 1 in fall-through).
- R10: A partial reset leaves the chosen discipline unchanged, whatever value `fwft_sel` has.
- R11: `rewind` high on an `rclk` edge resets the read pointer to the first location, with priority over `rd_en`. In fall-through mode it clears `st_rd`, and word 0 is fetched again on the next edge. It is meaningful while at most DEPTH words have been written since the last reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous active-high, sampled by both clocks; latches the discipline |
| prst | input | 1 | Partial reset, synchronous active-high, sampled by both clocks; keeps the discipline |
| fwft_sel | input | 1 | Discipline select sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write enable |
| din | input | WIDTH | Write data |
| rd_en | input | 1 | Read enable |
| rewind | input | 1 | Move the read pointer back to the first location |
| dout | output | WIDTH | Read data (registered memory output) |
| st_rd | output | 1 | Empty flag (demand-read) or output valid (fall-through) |
| st_wr | output | 1 | Full flag (demand-read) or room to write (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words in memory |

## Verification
The bench builds the block with DEPTH = 8 and WIDTH = 8 and drives both clocks from one source. A shallow memory makes the full boundary, the DEPTH+1 fall-through capacity and the half-full threshold at five words reachable within a few cycles. The single clock makes the two-edge synchronizer delay deterministic, so a count-based model can predict every flag on every edge, including the three-edge fall-through delay. Randomized traffic in both disciplines then exercises pointer wrap at twice the depth.

// File: rtl/mode_fifo_pkg.sv
package mode_fifo_pkg;
  typedef enum logic {
    TM_STD  = 1'b0,
    TM_FWFT = 1'b1
  } tmode_e;
endpackage

// File: rtl/fifo_dpram.sv
module fifo_dpram #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int PW     = 11,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (clr) chain[0] <= '0;
          else     chain[0] <= gray_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (clr) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < PW; i++) bin_out[i] = ^(chain[STAGES-1] >> i);
  end
endmodule

// File: rtl/fifo_wside.sv
module fifo_wside
  import mode_fifo_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int PW     = $clog2(DEPTH) + 1,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray,
  output logic          we,
  output logic [PW-2:0] waddr,
  output logic [PW-1:0] wgray,
  output tmode_e        mode,
  output logic          full,
  output logic          half_full
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  logic          clr;
  logic [PW-1:0] wbin, wbin_inc, rbin_s, occ;

  assign clr = mrst | prst;

  gray_sync #(.PW(PW), .STAGES(STAGES)) u_rsync (
    .clk     (clk),
    .clr     (clr),
    .gray_in (rgray),
    .bin_out (rbin_s)
  );

  assign occ       = wbin - rbin_s;
  assign full      = (occ == FULL_CNT);
  assign half_full = (occ > HALF_CNT);
  assign we        = wr_en & ~full & ~clr;
  assign waddr     = wbin[PW-2:0];
  assign wbin_inc  = wbin + 1'b1;

  always_ff @(posedge clk) begin
    if (mrst) mode <= tmode_e'(fwft_sel);
    if (clr) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_inc;
      wgray <= wbin_inc ^ (wbin_inc >> 1);
    end
  end
endmodule

// File: rtl/fifo_rside.sv
module fifo_rside
  import mode_fifo_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int PW     = $clog2(DEPTH) + 1,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          rd_en,
  input  logic          rewind,
  input  logic [PW-1:0] wgray,
  output logic          re,
  output logic [PW-2:0] raddr,
  output logic [PW-1:0] rgray,
  output tmode_e        mode,
  output logic          empty,
  output logic          out_vld
);
  logic          clr, avail, fetch;
  logic [PW-1:0] rbin, rbin_inc, wbin_s;

  assign clr = mrst | prst;

  gray_sync #(.PW(PW), .STAGES(STAGES)) u_wsync (
    .clk     (clk),
    .clr     (clr),
    .gray_in (wgray),
    .bin_out (wbin_s)
  );

  assign avail    = (wbin_s != rbin);
  assign empty    = ~avail;
  assign rbin_inc = rbin + 1'b1;
  assign raddr    = rbin[PW-2:0];
  assign re       = fetch;

  always_comb begin
    fetch = 1'b0;
    if (!clr && !rewind) begin
      if (mode == TM_FWFT) fetch = avail & (~out_vld | rd_en);
      else                 fetch = avail & rd_en;
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) mode <= tmode_e'(fwft_sel);
    if (clr || rewind) begin
      rbin    <= '0;
      rgray   <= '0;
      out_vld <= 1'b0;
    end else begin
      if (fetch) begin
        rbin  <= rbin_inc;
        rgray <= rbin_inc ^ (rbin_inc >> 1);
      end
      if (mode == TM_FWFT) begin
        if (fetch)      out_vld <= 1'b1;
        else if (rd_en) out_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mode_fifo.sv
module mode_fifo
  import mode_fifo_pkg::*;
#(
  parameter int WIDTH  = 18,
  parameter int DEPTH  = 1024,
  parameter int STAGES = 2
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst,
  input  logic             prst,
  input  logic             fwft_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_en,
  input  logic             rewind,
  output logic [WIDTH-1:0] dout,
  output logic             st_rd,
  output logic             st_wr,
  output logic             half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we, re, wfull, rempty, out_vld;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray;
  tmode_e        wmode, rmode;

  fifo_wside #(.DEPTH(DEPTH), .PW(PW), .STAGES(STAGES)) u_w (
    .clk       (wclk),
    .mrst      (mrst),
    .prst      (prst),
    .fwft_sel  (fwft_sel),
    .wr_en     (wr_en),
    .rgray     (rgray),
    .we        (we),
    .waddr     (waddr),
    .wgray     (wgray),
    .mode      (wmode),
    .full      (wfull),
    .half_full (half_full)
  );

  fifo_rside #(.DEPTH(DEPTH), .PW(PW), .STAGES(STAGES)) u_r (
    .clk      (rclk),
    .mrst     (mrst),
    .prst     (prst),
    .fwft_sel (fwft_sel),
    .rd_en    (rd_en),
    .rewind   (rewind),
    .wgray    (wgray),
    .re       (re),
    .raddr    (raddr),
    .rgray    (rgray),
    .mode     (rmode),
    .empty    (rempty),
    .out_vld  (out_vld)
  );

  fifo_dpram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk  (wclk),
    .we    (we),
    .waddr (waddr),
    .wdata (din),
    .rclk  (rclk),
    .re    (re),
    .raddr (raddr),
    .rdata (dout)
  );

  assign st_rd = (rmode == TM_FWFT) ? out_vld : rempty;
  assign st_wr = (wmode == TM_FWFT) ? ~wfull  : wfull;
endmodule

// File: rtl/mode_fifo_chk.sv
module mode_fifo_chk #(
  parameter int W  = 18,
  parameter int PW = 11
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          prst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rewind,
  input logic [W-1:0]  dout,
  input logic          st_rd,
  input logic          st_wr,
  input logic          half_full,
  input logic          wfull,
  input logic          rempty,
  input logic          out_vld,
  input logic          wmode,
  input logic          rmode,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  logic w_seen, r_seen;

  always_ff @(posedge wclk) if (mrst) w_seen <= 1'b1;
  always_ff @(posedge rclk) if (mrst) r_seen <= 1'b1;

  // R6: a refused write leaves the write pointer where it was
  p_full_hold_r6: assert property (@(posedge wclk)
    disable iff (w_seen !== 1'b1 || mrst || prst)
    (wfull && wr_en) |=> $stable(wgray));

  // R6: a read from an empty demand-read FIFO does not move the read pointer
  p_empty_hold_r6: assert property (@(posedge rclk)
    disable iff (r_seen !== 1'b1 || mrst || prst)
    (!rmode && rempty && rd_en && !rewind) |=> $stable(rgray));

  // R2: demand-read output holds unless a real read happens
  p_std_hold_r2: assert property (@(posedge rclk)
    disable iff (r_seen !== 1'b1 || mrst || prst)
    (!rmode && !$isunknown(dout) && !(rd_en && !rempty)) |=> $stable(dout));

  // R5: a valid fall-through word stays put until it is read
  p_fwft_hold_r5: assert property (@(posedge rclk)
    disable iff (r_seen !== 1'b1 || mrst || prst)
    (rmode && out_vld && !rd_en && !rewind) |=> (out_vld && $stable(dout)));

  // R11: rewind in fall-through mode drops the output word
  p_rewind_drop_r11: assert property (@(posedge rclk)
    disable iff (r_seen !== 1'b1 || mrst || prst)
    (rmode && rewind) |=> !st_rd);

  // R9: read side is empty right after either reset
  p_rd_reset_r9: assert property (@(posedge rclk)
    disable iff (r_seen !== 1'b1)
    (mrst || prst) |=> (st_rd == !rmode));

  // R9: write side is empty right after either reset
  p_wr_reset_r9: assert property (@(posedge wclk)
    disable iff (w_seen !== 1'b1)
    (mrst || prst) |=> (!half_full && (st_wr == wmode)));

  // R10: partial reset keeps the discipline
  p_mode_keep_r10: assert property (@(posedge wclk)
    disable iff (w_seen !== 1'b1 || mrst)
    prst |=> $stable(wmode));
endmodule

bind mode_fifo mode_fifo_chk #(.W(WIDTH), .PW(PW)) u_chk (
  .wclk      (wclk),
  .rclk      (rclk),
  .mrst      (mrst),
  .prst      (prst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rewind    (rewind),
  .dout      (dout),
  .st_rd     (st_rd),
  .st_wr     (st_wr),
  .half_full (half_full),
  .wfull     (wfull),
  .rempty    (rempty),
  .out_vld   (out_vld),
  .wmode     (wmode),
  .rmode     (rmode),
  .wgray     (wgray),
  .rgray     (rgray)
);

// File: tb/sim_mode_fifo.sv
module sim_mode_fifo;
  localparam int D  = 8;
  localparam int D2 = 2 * D;
  localparam int WD = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
  logic [WD-1:0] din = '0;
  logic [WD-1:0] dout;
  logic          st_rd, st_wr, half_full;

  mode_fifo #(.WIDTH(WD), .DEPTH(D), .STAGES(2)) u0 (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .din(din), .rd_en(rd_en), .rewind(rewind),
    .dout(dout), .st_rd(st_rd), .st_wr(st_wr), .half_full(half_full)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit armed = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // behavioural model: counts modulo 2*D, two-edge view delay each way
  int m_w = 0, m_r = 0, m_ws1 = 0, m_ws2 = 0, m_rs1 = 0, m_rs2 = 0;
  bit m_fw_w = 0, m_fw_r = 0, m_ov = 0, m_dqk = 0;
  logic [WD-1:0] m_dq = '0;
  logic [WD-1:0] m_mem [D];

  always @(posedge clk) begin
    int ro, wo, occ;
    bit fullw, av;
    ro = m_r; wo = m_w;
    occ = (m_w - m_rs2 + D2) % D2;
    fullw = (occ == D);
    av = (m_ws2 != m_r);
    if (mrst) begin m_fw_r = fwft_sel; m_fw_w = fwft_sel; armed = 1; end
    if (mrst || prst) begin
      m_r = 0; m_ov = 0; m_ws1 = 0; m_ws2 = 0;
    end else begin
      m_ws2 = m_ws1; m_ws1 = wo;
      if (rewind) begin m_r = 0; m_ov = 0; end
      else if (!m_fw_r) begin
        if (rd_en && av) begin m_dq = m_mem[m_r % D]; m_dqk = 1; m_r = (m_r + 1) % D2; end
      end else if (av && (!m_ov || rd_en)) begin
        m_dq = m_mem[m_r % D]; m_r = (m_r + 1) % D2; m_ov = 1;
      end else if (rd_en) m_ov = 0;
    end
    if (mrst || prst) begin
      m_w = 0; m_rs1 = 0; m_rs2 = 0;
    end else begin
      m_rs2 = m_rs1; m_rs1 = ro;
      if (wr_en && !fullw) begin m_mem[m_w % D] = din; m_w = (m_w + 1) % D2; end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      int occ;
      bit full;
      occ = (m_w - m_rs2 + D2) % D2;
      full = (occ == D);
      chk("R3/R5 st_rd model", st_rd, m_fw_r ? m_ov : (m_ws2 == m_r));
      chk("R3/R5 st_wr model", st_wr, m_fw_w ? !full : full);
      chk("R8 half_full model", half_full, occ > D / 2);
      if (m_fw_r ? m_ov : m_dqk) chk("R2/R5 dout model", dout, m_dq);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic step(input bit w, input logic [WD-1:0] d, input bit r, input bit rw);
    wr_en = w; din = d; rd_en = r; rewind = rw;
    @(negedge clk);
    wr_en = 0; rd_en = 0; rewind = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0);
  endtask

  task automatic master(input bit sel);
    mrst = 1; fwft_sel = sel;
    idle(2);
    mrst = 0; fwft_sel = !sel;
  endtask

  task automatic partial(input bit sel);
    prst = 1; fwft_sel = sel;
    idle(1);
    prst = 0;
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) step($urandom % 2, WD'($urandom), ($urandom % 3) != 0, 0);
  endtask

  initial begin
    @(negedge clk);
    idle(3);
    chk("R9 reset st_rd", st_rd, 1);
    chk("R9 reset st_wr", st_wr, 0);
    chk("R9 reset half_full", half_full, 0);
    mrst = 0; fwft_sel = 1;

    // demand-read latency and data
    step(1, 8'hA1, 0, 0);
    chk("R7 empty after write edge", st_rd, 1);
    idle(1);
    chk("R7 empty one edge later", st_rd, 1);
    idle(1);
    chk("R7 not empty two edges later", st_rd, 0);
    chk("R1 fwft_sel ignored outside reset", st_rd, 0);
    step(0, '0, 1, 0);
    chk("R2 read data", dout, 8'hA1);
    chk("R3 empty after last read", st_rd, 1);
    idle(3);

    for (int i = 0; i < 10; i++) step(1, WD'(8'h10 + i), 0, 0);
    idle(3);
    chk("R3 full flag", st_wr, 1);
    chk("R8 half_full when full", half_full, 1);
    for (int i = 0; i < 8; i++) begin
      step(0, '0, 1, 0);
      chk("R2 ordered read", dout, WD'(8'h10 + i));
    end
    chk("R6 no overflow word kept", st_rd, 1);
    step(0, '0, 1, 0);
    step(0, '0, 1, 0);
    chk("R6 read when empty holds dout", dout, 8'h17);
    chk("R6 still empty", st_rd, 1);

    // partial reset keeps demand-read
    partial(1);
    chk("R10 mode kept st_rd", st_rd, 1);
    chk("R10 mode kept st_wr", st_wr, 0);

    // half-full threshold
    for (int i = 0; i < 4; i++) step(1, WD'(8'h20 + i), 0, 0);
    chk("R8 four words not half", half_full, 0);
    step(1, 8'h24, 0, 0);
    chk("R8 five words half", half_full, 1);

    // demand-read rewind
    idle(3);
    step(0, '0, 1, 0);
    step(0, '0, 1, 0);
    chk("R2 second word", dout, 8'h21);
    step(0, '0, 1, 1);
    chk("R11 rewind keeps dout in demand-read", dout, 8'h21);
    chk("R11 rewind not empty", st_rd, 0);
    step(0, '0, 1, 0);
    chk("R11 replay first word", dout, 8'h20);

    // fall-through
    master(1);
    chk("R1 fall-through st_rd", st_rd, 0);
    chk("R1 fall-through st_wr", st_wr, 1);
    step(1, 8'hC3, 0, 0);
    idle(2);
    chk("R4 not yet after two edges", st_rd, 0);
    idle(1);
    chk("R4 ready after third edge", st_rd, 1);
    chk("R4 head word", dout, 8'hC3);
    step(0, '0, 1, 0);
    chk("R5 ready drops when drained", st_rd, 0);
    idle(3);

    for (int i = 0; i < 12; i++) step(1, WD'(8'h40 + i), 0, 0);
    idle(3);
    chk("R5 no room at DEPTH+1", st_wr, 0);
    chk("R5 head valid", st_rd, 1);
    chk("R5 head data", dout, 8'h40);
    for (int i = 0; i < 8; i++) begin
      step(0, '0, 1, 0);
      chk("R5 advance", dout, WD'(8'h41 + i));
    end
    step(0, '0, 1, 0);
    chk("R6 dropped writes never appear", st_rd, 0);

    // fall-through rewind
    partial(0);
    chk("R10 fall-through kept", st_wr, 1);
    for (int i = 0; i < 5; i++) step(1, WD'(8'h60 + i), 0, 0);
    idle(4);
    chk("R5 first of batch", dout, 8'h60);
    step(0, '0, 1, 0);
    step(0, '0, 1, 0);
    chk("R5 third of batch", dout, 8'h62);
    step(0, '0, 1, 1);
    chk("R11 rewind drops ready", st_rd, 0);
    idle(1);
    chk("R11 refetched ready", st_rd, 1);
    chk("R11 refetched word 0", dout, 8'h60);

    // randomized traffic in both disciplines
    master(1);
    random_run(3000);
    master(0);
    random_run(3000);
    idle(6);
    report();
  end
endmodule